// File: doc/BRIEF.md
# Multiplexed Bus Master Sequencer

This block runs DMA transfers over a 16-bit shared address/data bus while the device owns that bus. An internal DMA engine hands it a burst request made of a start address, a direction and a transfer count. The block asks for the bus and waits for a grant. For each word it then runs a one-cycle address phase followed by a data phase, and it advances the address by two bytes between words.

The sequencer drives the pins a master owns: the bus lines, an address strobe, an active-low data strobe, the transfer direction, and two controls that steer an external transceiver inward or outward. The pad ring applies the high-impedance state through a shared master enable and a separate enable for the data lines. A slave terminates each data phase with a ready acknowledge. If the slave stays silent for too long, the memory error flag is set and the burst is abandoned. When a configuration bit is set, the host can end a burst early through a release pin. When the bit is clear, that pin is an output that the block pulls low while it is master. The block also combines five status flags into an open-drain attention interrupt.

Top module: `mbus_master_seq`

## Requirements
- R1: Under synchronous reset (rst_n low at a clock edge) the block goes idle. `bus_req`, `mst_oe`, `dal_oe`, `rel_oe`, `rd_valid`, `merr` and `irq_pull` are 0, and `das_n_out` and `slave_das` are 1.
- R2: An accepted `req_valid` raises `bus_req` on the next cycle. The block drives no master pin (`mst_oe`=0) until it samples `bus_grant` high. The address phase starts in the cycle after the grant is sampled.
- R3: The address phase lasts exactly one cycle. In that cycle `mst_oe`=1, `dal_oe`=1, `dal_out` holds the current address and `as_out`=1. `as_out` is 0 in every other cycle.
- R4: `dir_out` is 1 for a read burst (the block receives) and 0 for a write burst, for every cycle in which `mst_oe`=1.
- R5: `xcvr_in` is 1 only during the data phase of a read. It is never 1 during a write.
- R6: `xcvr_out` is 1 during the address phase of a read and during every address and data cycle of a write.
- R7: `das_n_out` is 0 from the first data-phase cycle through the cycle in which `ready_in` is sampled high. It is 1 in the following cycle. In a write data phase, `dal_oe`=1, `dal_out`=`wr_data` and `wr_take`=1 in the ready cycle.
- R8: A burst makes `req_len` transfers, and a length of 0 means one transfer. Each next address is the previous address plus 2, modulo 2^16.
- R9: In the cycle after the last transfer completes, `mst_oe`, `dal_oe` and `bus_req` are 0.
- R10: When `cfg_rel_en`=1, a high `rel_in` seen during a burst ends it after the transfer in progress completes. When `cfg_rel_en`=0, `rel_in` has no effect on the number of transfers, and `rel_oe` equals `mst_oe`.
- R11: If `ready_in` stays low for 64 data-phase cycles, the burst is aborted. The block is idle with `mst_oe`=0 in the next cycle, and `merr` is set in that same cycle. `merr` stays set until `merr_clr`.
- R12: `irq_pull` is 1 in the cycle after `irq_en`=1 while any of `ext_flags[3:0]` (missed frame, receive, transmit, init done) or `merr` is set. Otherwise it is 0.
- R13: For a read, the value on `dal_in` at the ready edge appears on `rd_data`, with `rd_valid`=1 for exactly one cycle after it.
- R14: `slave_das` is `das_in` registered one cycle while `mst_oe`=0, and it is 1 while the block is master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Burst request from the DMA engine, taken when idle |
| req_addr | input | 16 | Start byte address |
| req_read | input | 1 | 1 = read burst, 0 = write burst |
| req_len | input | 8 | Transfer count (0 means 1) |
| wr_data | input | 16 | Write word for the current transfer |
| wr_take | output | 1 | Current write word consumed this cycle |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | One-cycle pulse, rd_data new |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| dal_out | output | 16 | Value driven onto the shared bus |
| dal_in | input | 16 | Value sampled from the shared bus |
| dal_oe | output | 1 | Enable for the shared bus drivers |
| as_out | output | 1 | Address strobe pulse |
| dir_out | output | 1 | Transfer direction, 1 = receive |
| das_n_out | output | 1 | Data strobe, low during data phase |
| das_in | input | 1 | Data strobe pin value as a slave |
| xcvr_in | output | 1 | Transceiver steered inward |
| xcvr_out | output | 1 | Transceiver steered outward |
| mst_oe | output | 1 | Enable for all master-driven control pins |
| ready_in | input | 1 | Slave ready acknowledge |
| cfg_rel_en | input | 1 | Configuration: release pin is an input |
| rel_in | input | 1 | Host release request |
| rel_oe | output | 1 | Release pin pulled low as output |
| slave_das | output | 1 | Registered slave strobe sample |
| ext_flags | input | 4 | Missed frame, receive, transmit, init done |
| irq_en | input | 1 | Interrupt enable |
| merr_clr | input | 1 | Clear the memory error flag |
| merr | output | 1 | Memory error flag |
| irq_pull | output | 1 | Drive the open-drain interrupt pin low |

## Verification
The bench follows the boundary cases where a sequencer most easily slips by one cycle. These are a zero-latency ready in the first data cycle, a ready in the very last timeout cycle against one that never comes, and a release raised in the data phase of the second word. A design that counted the timeout one short would abort a transfer the slave actually acknowledged. A design that acted on release at once would cut off the word in progress. One that ignored the configuration bit would shorten bursts the host never asked to end. Address wrap-around past 0xFFFE, a zero length and the tristate cycle after the final word are also checked, because off-by-one length or enable logic would leave the bus driven or add a phantom transfer.

// File: rtl/mbs_pkg.sv
// Package: shared types for the multiplexed bus master sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mbs_pkg;
    // Sequencer phases; ADDR and DATA are the bus-owning phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ADDR = 2'd2,
        ST_DATA = 2'd3
    } seq_state_t;
endpackage

// File: rtl/mbs_fsm.sv
// Module: mbs_fsm
// Runs the burst: request/grant handshake, one-cycle address phase, data
// phase ended by ready or by a timeout, address stepping and release.
// Assumes the request is held stable only in the cycle req_valid is high.
module mbs_fsm
    import mbs_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LEN_W     = 8,
    parameter int TMO       = 64,
    parameter int ADDR_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DW-1:0]    req_addr,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic             bus_grant,
    input  logic             ready_in,
    input  logic             rel_act,
    output seq_state_t       state_o,
    output logic [DW-1:0]    addr_o,
    output logic             rd_o,
    output logic             tmo_o
);
    localparam int WAIT_W = (TMO > 2) ? $clog2(TMO) : 1;
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TMO - 1);

    seq_state_t       state_q;
    logic [DW-1:0]    addr_q;
    logic             rd_q;
    logic [LEN_W-1:0] left_q;
    logic [WAIT_W-1:0] wait_q;
    logic             rel_q;
    logic             xfer_end;
    logic             last_xfer;

    // Purpose: flag the data phase ending with an acknowledge and whether it closes the burst.
    always_comb begin
        xfer_end  = (state_q == ST_DATA) && ready_in;
        last_xfer = (left_q == LEN_W'(1)) || rel_q || rel_act;
    end

    // Purpose: timeout fires when the last allowed wait cycle passes without ready.
    always_comb begin
        tmo_o = (state_q == ST_DATA) && !ready_in && (wait_q == WAIT_LAST);
    end

    // Purpose: phase sequencing, address/count bookkeeping and release latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            left_q  <= '0;
            wait_q  <= '0;
            rel_q   <= 1'b0;
        end else begin
            if (state_q != ST_IDLE && rel_act) begin
                rel_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        rd_q    <= req_read;
                        left_q  <= (req_len == '0) ? LEN_W'(1) : req_len;
                        rel_q   <= 1'b0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (bus_grant) begin
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    wait_q  <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (xfer_end) begin
                        if (last_xfer) begin
                            state_q <= ST_IDLE;
                        end else begin
                            left_q  <= left_q - LEN_W'(1);
                            addr_q  <= addr_q + DW'(ADDR_STEP);
                            state_q <= ST_ADDR;
                        end
                    end else if (tmo_o) begin
                        state_q <= ST_IDLE;
                    end else begin
                        wait_q <= wait_q + WAIT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign addr_o  = addr_q;
    assign rd_o    = rd_q;

    // R2: without a grant the block stays in the request phase.
    assert_wait_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && !bus_grant) |=> (state_q == ST_REQ));

    // R9: the final acknowledged transfer returns the sequencer to idle.
    assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && ready_in && left_q == LEN_W'(1)) |=> (state_q == ST_IDLE));

    // R8: a continuing burst steps the address by the configured stride.
    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !last_xfer) |=> (addr_q == $past(addr_q) + DW'(ADDR_STEP)));

    // R11: a timeout abandons the burst.
    assert_tmo_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> (state_q == ST_IDLE));
endmodule

// File: rtl/mbs_pins.sv
// Module: mbs_pins
// Decodes the current phase into master pin values and output enables.
// Assumes the pad ring applies high impedance from mst_oe and dal_oe.
module mbs_pins
    import mbs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state_i,
    input  logic [DW-1:0] addr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wr_data,
    input  logic          ready_in,
    input  logic          cfg_rel_en,
    output logic          mst_oe,
    output logic          bus_req,
    output logic          dal_oe,
    output logic [DW-1:0] dal_out,
    output logic          as_out,
    output logic          das_n_out,
    output logic          dir_out,
    output logic          xcvr_in,
    output logic          xcvr_out,
    output logic          rel_oe,
    output logic          wr_take
);
    logic in_addr;
    logic in_data;

    // Purpose: phase decode shared by every pin below.
    always_comb begin
        in_addr = (state_i == ST_ADDR);
        in_data = (state_i == ST_DATA);
    end

    // Purpose: ownership, strobes and transceiver steering per phase and direction.
    always_comb begin
        mst_oe    = in_addr || in_data;
        bus_req   = (state_i != ST_IDLE);
        as_out    = in_addr;
        das_n_out = !in_data;
        dir_out   = mst_oe && rd_i;
        xcvr_in   = in_data && rd_i;
        xcvr_out  = in_addr || (in_data && !rd_i);
        rel_oe    = mst_oe && !cfg_rel_en;
    end

    // Purpose: bus drive value and the write-word handshake.
    always_comb begin
        dal_oe  = in_addr || (in_data && !rd_i);
        dal_out = '0;
        if (in_addr) begin
            dal_out = addr_i;
        end else if (in_data && !rd_i) begin
            dal_out = wr_data;
        end
        wr_take = in_data && !rd_i && ready_in;
    end

    // R5: the transceiver is never steered both ways at once.
    assert_xcvr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(xcvr_in && xcvr_out));

    // R3: the address strobe only ever appears while the bus is owned.
    assert_as_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        as_out |-> (mst_oe && dal_oe));

    // R9: bus lines are only driven by an owning master.
    assert_dal_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dal_oe |-> mst_oe);

    // R3: one-cycle address phase is always followed by a strobe-low data cycle.
    assert_addr_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        as_out |=> (!as_out && !das_n_out));
endmodule

// File: rtl/mbs_irq.sv
// Module: mbs_irq
// Holds the sticky memory error flag and forms the registered open-drain
// interrupt request from the enable and the status flags.
// Assumes a timeout and a clear in the same cycle leave the flag set.
module mbs_irq #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_i,
    input  logic             merr_clr,
    input  logic [NFLAG-1:0] ext_flags,
    input  logic             irq_en,
    output logic             merr,
    output logic             irq_pull
);
    logic merr_q;
    logic irq_q;

    // Purpose: sticky memory error flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merr_q <= 1'b0;
        end else if (tmo_i) begin
            merr_q <= 1'b1;
        end else if (merr_clr) begin
            merr_q <= 1'b0;
        end
    end

    // Purpose: registered interrupt pull-down request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_en && ((|ext_flags) || merr_q);
        end
    end

    assign merr     = merr_q;
    assign irq_pull = irq_q;

    // R12: a disabled interrupt never pulls the pin.
    assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_pull);

    // R11: a timeout always leaves the error flag set.
    assert_merr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> merr);
endmodule

// File: rtl/mbus_master_seq.sv
// Module: mbus_master_seq (top)
// Bus master sequencer for a 16-bit multiplexed address/data bus: wires the
// phase sequencer, the pin decoder and the interrupt logic, and registers
// read data and the slave-side strobe sample.
// Assumes bus_grant is held while the block owns the bus.
module mbus_master_seq
    import mbs_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LEN_W     = 8,
    parameter int TMO       = 64,
    parameter int ADDR_STEP = 2,
    parameter int NFLAG     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DW-1:0]    req_addr,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             bus_req,
    input  logic             bus_grant,
    output logic [DW-1:0]    dal_out,
    input  logic [DW-1:0]    dal_in,
    output logic             dal_oe,
    output logic             as_out,
    output logic             dir_out,
    output logic             das_n_out,
    input  logic             das_in,
    output logic             xcvr_in,
    output logic             xcvr_out,
    output logic             mst_oe,
    input  logic             ready_in,
    input  logic             cfg_rel_en,
    input  logic             rel_in,
    output logic             rel_oe,
    output logic             slave_das,
    input  logic [NFLAG-1:0] ext_flags,
    input  logic             irq_en,
    input  logic             merr_clr,
    output logic             merr,
    output logic             irq_pull
);
    seq_state_t    state_w;
    logic [DW-1:0] addr_w;
    logic          rd_w;
    logic          tmo_w;
    logic          rel_act;
    logic [DW-1:0] rd_data_q;
    logic          rd_valid_q;
    logic          slave_das_q;

    // Purpose: release pin only acts as an input when configured so.
    always_comb begin
        rel_act = cfg_rel_en && rel_in;
    end

    mbs_fsm #(
        .DW(DW), .LEN_W(LEN_W), .TMO(TMO), .ADDR_STEP(ADDR_STEP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_read(req_read),
        .req_len(req_len), .bus_grant(bus_grant), .ready_in(ready_in),
        .rel_act(rel_act), .state_o(state_w), .addr_o(addr_w),
        .rd_o(rd_w), .tmo_o(tmo_w)
    );

    mbs_pins #(.DW(DW)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .state_i(state_w), .addr_i(addr_w), .rd_i(rd_w),
        .wr_data(wr_data), .ready_in(ready_in), .cfg_rel_en(cfg_rel_en),
        .mst_oe(mst_oe), .bus_req(bus_req), .dal_oe(dal_oe),
        .dal_out(dal_out), .as_out(as_out), .das_n_out(das_n_out),
        .dir_out(dir_out), .xcvr_in(xcvr_in), .xcvr_out(xcvr_out),
        .rel_oe(rel_oe), .wr_take(wr_take)
    );

    mbs_irq #(.NFLAG(NFLAG)) u_irq (
        .clk(clk), .rst_n(rst_n), .tmo_i(tmo_w), .merr_clr(merr_clr),
        .ext_flags(ext_flags), .irq_en(irq_en),
        .merr(merr), .irq_pull(irq_pull)
    );

    // Purpose: capture the read word at the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (state_w == ST_DATA && rd_w && ready_in) begin
                rd_data_q  <= dal_in;
                rd_valid_q <= 1'b1;
            end
        end
    end

    // Purpose: sample the strobe pin as a slave; idle high while master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_das_q <= 1'b1;
        end else begin
            slave_das_q <= mst_oe ? 1'b1 : das_in;
        end
    end

    assign rd_data   = rd_data_q;
    assign rd_valid  = rd_valid_q;
    assign slave_das = slave_das_q;

    // R13: an acknowledged read data phase yields a read-valid pulse.
    assert_rd_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_in && ready_in) |=> rd_valid);

    // R14: while the bus is owned the slave sample reads high next cycle.
    assert_slave_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        mst_oe |=> slave_das);
endmodule

// File: tb/mbus_master_seq_bench.sv
// Bench: behavioural cycle model of the sequencer compared on every clock,
// plus burst-level transfer-count and flag checks.
module mbus_master_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_read = 1'b0;
    logic [7:0]  req_len = '0;
    logic [15:0] wr_data = '0;
    logic        bus_grant = 1'b0;
    logic [15:0] dal_in = '0;
    logic        das_in = 1'b1;
    logic        ready_in = 1'b0;
    logic        cfg_rel_en = 1'b0;
    logic        rel_in = 1'b0;
    logic [3:0]  ext_flags = '0;
    logic        irq_en = 1'b0;
    logic        merr_clr = 1'b0;

    logic        wr_take, rd_valid, bus_req, dal_oe, as_out, dir_out, das_n_out;
    logic        xcvr_in, xcvr_out, mst_oe, rel_oe, slave_das, merr, irq_pull;
    logic [15:0] rd_data, dal_out;

    mbus_master_seq u_mbus_master_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_len(req_len), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_req(bus_req), .bus_grant(bus_grant), .dal_out(dal_out),
        .dal_in(dal_in), .dal_oe(dal_oe), .as_out(as_out), .dir_out(dir_out),
        .das_n_out(das_n_out), .das_in(das_in), .xcvr_in(xcvr_in),
        .xcvr_out(xcvr_out), .mst_oe(mst_oe), .ready_in(ready_in),
        .cfg_rel_en(cfg_rel_en), .rel_in(rel_in), .rel_oe(rel_oe),
        .slave_das(slave_das), .ext_flags(ext_flags), .irq_en(irq_en),
        .merr_clr(merr_clr), .merr(merr), .irq_pull(irq_pull)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Reference model state: 0 idle, 1 request, 2 address, 3 data.
    int          m_st = 0;
    int          m_addr = 0;
    bit          m_rd = 0;
    int          m_left = 0;
    int          m_wait = 0;
    bit          m_rel = 0;
    bit          m_merr = 0;
    bit          m_irq = 0;
    bit          m_rdv = 0;
    int          m_rdd = 0;
    bit          m_slv = 1;

    // Model step on each rising edge, all from pre-edge values.
    always @(posedge clk) begin
        bit owner;
        bit relnow;
        bit tmo;
        owner = (m_st == 2 || m_st == 3);
        relnow = m_rel || (cfg_rel_en && rel_in);
        tmo = 0;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_rd = 0; m_left = 0; m_wait = 0; m_rel = 0;
            m_merr = 0; m_irq = 0; m_rdv = 0; m_rdd = 0; m_slv = 1;
        end else begin
            m_irq = irq_en && ((ext_flags != 0) || m_merr);
            m_slv = owner ? 1'b1 : das_in;
            m_rdv = 0;
            if (m_st != 0 && cfg_rel_en && rel_in) m_rel = 1;
            case (m_st)
                0: if (req_valid) begin
                    m_addr = req_addr; m_rd = req_read;
                    m_left = (req_len == 0) ? 1 : req_len;
                    m_rel = 0; m_st = 1;
                end
                1: if (bus_grant) m_st = 2;
                2: begin m_wait = 0; m_st = 3; end
                default: begin
                    if (ready_in) begin
                        if (m_rd) begin m_rdv = 1; m_rdd = dal_in; end
                        if (m_left == 1 || relnow) m_st = 0;
                        else begin m_left--; m_addr = (m_addr + 2) % 65536; m_st = 2; end
                    end else if (m_wait == 63) begin
                        tmo = 1; m_st = 0;
                    end else m_wait++;
                end
            endcase
            if (tmo) m_merr = 1;
            else if (merr_clr) m_merr = 0;
        end
    end

    int xfers = 0;
    int lat = 1;
    int gdelay = 1;
    int rel_trig = -1;
    int cyc = 0;
    int wr_idx = 0;

    // Every cycle, 2 ns after the falling edge: compare all outputs with the model.
    always begin
        bit own;
        bit dat;
        bit adr;
        @(negedge clk);
        #2;
        cyc++;
        own = (m_st == 2 || m_st == 3);
        adr = (m_st == 2);
        dat = (m_st == 3);
        chk(own ? "R4 dir_out" : "R1 dir_out idle", dir_out, own && m_rd);
        chk("R2 bus_req", bus_req, m_st != 0);
        chk("R9 mst_oe", mst_oe, own);
        chk("R9 dal_oe", dal_oe, adr || (dat && !m_rd));
        if (dal_oe) chk(adr ? "R3 dal_out addr" : "R7 dal_out data", dal_out,
                        adr ? m_addr : wr_data);
        chk("R3 as_out", as_out, adr);
        chk("R7 das_n_out", das_n_out, !dat);
        chk("R5 xcvr_in", xcvr_in, dat && m_rd);
        chk("R6 xcvr_out", xcvr_out, adr || (dat && !m_rd));
        chk("R10 rel_oe", rel_oe, own && !cfg_rel_en);
        chk("R7 wr_take", wr_take, dat && !m_rd && ready_in);
        chk("R13 rd_valid", rd_valid, m_rdv);
        chk("R13 rd_data", rd_data, m_rdd);
        chk("R11 merr", merr, m_merr);
        chk("R12 irq_pull", irq_pull, m_irq);
        chk("R14 slave_das", slave_das, m_slv);
        if (!das_n_out && ready_in) xfers++;
        if (wr_take) wr_idx++;
    end

    // Slave and host responder: ready after lat wait cycles, grant, release, bus data.
    int rcnt = 0;
    int gcnt = 0;
    always @(negedge clk) begin
        if (mst_oe && !das_n_out) begin
            ready_in <= (rcnt >= lat);
            rcnt++;
        end else begin
            ready_in <= 1'b0;
            rcnt = 0;
        end
        if (bus_req) begin
            bus_grant <= (gcnt >= gdelay);
            gcnt++;
        end else begin
            bus_grant <= 1'b0;
            gcnt = 0;
        end
        rel_in  <= (rel_trig >= 0) && (xfers == rel_trig) && !das_n_out;
        dal_in  <= 16'h5A00 ^ 16'(cyc);
        wr_data <= 16'h3C00 + 16'(wr_idx);
        das_in  <= cyc[2];
    end

    task automatic burst(input logic [15:0] a, input bit rd, input logic [7:0] n,
                         input int expect_x, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_read = rd; req_len = n;
        xfers = 0;
        @(negedge clk);
        req_valid = 1'b0;
        while (m_st != 0) @(negedge clk);
        #3;
        chk(tag, xfers, expect_x);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk("R1 reset bus_req", bus_req, 0);
        chk("R1 reset irq_pull", irq_pull, 0);
        rst_n = 1'b1;
        gdelay = 3; lat = 1;
        burst(16'h1000, 0, 8'd3, 3, "R8 write burst count");
        gdelay = 0; lat = 0;
        burst(16'hFFFE, 1, 8'd2, 2, "R8 read wrap count");
        burst(16'h2222, 1, 8'd0, 1, "R8 zero length");
        lat = 2; cfg_rel_en = 1'b1; rel_trig = 1;
        burst(16'h0400, 1, 8'd5, 2, "R10 release ends burst");
        cfg_rel_en = 1'b0;
        burst(16'h0500, 0, 8'd3, 3, "R10 release ignored");
        rel_trig = -1; lat = 63;
        burst(16'h0600, 1, 8'd1, 1, "R11 ready in last wait cycle");
        chk("R11 no error on late ready", merr, 0);
        lat = 200; irq_en = 1'b1;
        burst(16'h0700, 1, 8'd2, 0, "R11 timeout aborts");
        repeat (2) @(negedge clk);
        #3;
        chk("R11 merr sticky", merr, 1);
        chk("R12 irq from merr", irq_pull, 1);
        @(negedge clk); merr_clr = 1'b1;
        @(negedge clk); merr_clr = 1'b0; ext_flags = 4'b0100;
        repeat (2) @(negedge clk);
        #3;
        chk("R12 irq from flag", irq_pull, 1);
        @(negedge clk); irq_en = 1'b0;
        repeat (2) @(negedge clk);
        #3;
        chk("R12 irq disabled", irq_pull, 0);
        ext_flags = '0;
        lat = 1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        burst(16'h0800, 0, 8'd1, 1, "R1 burst after reset");
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule